// File: doc/BRIEF.md
# Multiprocessor Serial Port with Address Filtering

This block is a full-duplex asynchronous serial port driven through a small register window. The host writes a byte to the data address to send it, and reads the same address to fetch the last byte received. Frames carry 8 data bits, or 8 data bits and a ninth bit. Timing comes from an external enable that pulses sixteen times per bit period, so no baud divider lives inside the block.

Receive and transmit completion are reported through two flags that only the host can clear, and an interrupt line stays high while either flag is set. The receiver has its own holding register, so the next frame can arrive while the host has not yet read the previous byte. The port also reports two errors: a frame whose stop bit reads low, and a byte that replaced an unread one.

In multiprocessor mode, used with 9-bit frames, the receiver ignores traffic meant for other stations. A frame with its ninth bit set is an address. It is accepted when it matches the station address in every bit the mask selects, or when all nine bits are ones (broadcast). After a match, data frames (ninth bit clear) are accepted until the host turns multiprocessor mode off.

Top module: `mpu_uart`

## Requirements
- R1: After reset every register reads 0, `txd` is 1 and `irq` is 0. The register addresses are: 0 = data, 1 = control, 2 = error, 3 = station address, 4 = address mask.
- R2: A host write to address 0 while the transmitter is idle sends, in this order: a 0 start bit, the 8 data bits LSB first, then the control bit 2 value if control bit 5 (9-bit mode) is 1, then a 1 stop bit. Each bit lasts 16 tick pulses. A write to address 0 while a frame is being sent is ignored.
- R3: Control bit 1 (transmit done) is set on the clock edge at which the stop bit ends.
- R4: The receiver sees a start on a high-to-low edge of `rxd` and checks it again on the 8th tick. If the line has gone high by then, the frame is dropped with no effect. Otherwise each later bit is sampled 16 ticks after the one before it. An accepted frame loads its byte into the holding register, which reads at address 0, and sets control bit 0 (receive done).
- R5: Hardware only sets control bits 0 and 1 and error bits 0 and 1. A host write of 0 to one of these bits clears it, and a write of 1 leaves it unchanged. `irq` is 1 exactly while control bit 0 or bit 1 is 1.
- R6: Control bit 3 holds the ninth bit of the last accepted frame in 9-bit mode, and the sampled stop bit in 8-bit mode.
- R7: If an accepted frame's sampled stop bit is 0, error bit 0 is set. The byte is still delivered.
- R8: A read of address 0 with `host_rd` high marks the held byte as read. If a frame is accepted while the held byte is unread, error bit 1 (overrun) is set and the new byte replaces the old one.
- R9: While control bit 4 (receive enable) is 0, `rxd` is ignored, and the holding register and control bit 0 stay unchanged.
- R10: With control bits 5 and 6 both 1, an address frame (ninth bit 1) is accepted only if ((byte XOR station) AND mask) is 0, or if all nine bits are 1. A data frame (ninth bit 0) is discarded unless an address has matched. Discarded frames change neither the holding register nor control bit 0.
- R11: After an address match, data frames are accepted, and an address frame that does not match is discarded without cancelling the match. Clearing control bit 6 cancels the match.
- R12: Control bits 2, 4, 5 and 6, the station address and the mask read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling enable, 16 pulses per bit |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe, marks the data byte as read |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idles high |
| irq | output | 1 | High while a completion flag is set |

## Verification
Register reads are combinational, and a write takes effect at the edge that samples it. The bench therefore drives and reads on the falling edge, one cycle apart. A received byte and its flags change at the edge after the stop bit's mid-sample: 8 ticks into the stop bit, plus three synchronizer clocks. The bench looks at them only after it has held the stop bit for its full length and the line has idled for one more bit. Transmitted bits are sampled half a bit after each bit boundary, counted from the start bit. Transmit done is due at the end of the stop bit, and the bench reads it well after that point.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
    localparam int unsigned A_DATA  = 0;
    localparam int unsigned A_CTRL  = 1;
    localparam int unsigned A_ERR   = 2;
    localparam int unsigned A_SADDR = 3;
    localparam int unsigned A_MASK  = 4;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/mpu_tx.sv
module mpu_tx #(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic          nine,
    input  logic [DW-1:0] din,
    input  logic          b8,
    output logic          busy,
    output logic          done,
    output logic          txd
);
    localparam int FW = DW + 3;
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(FW + 1);

    typedef struct packed {
        logic          busy;
        logic [FW-1:0] sh;
        logic [BW-1:0] bits;
        logic [BW-1:0] last;
        logic [CW-1:0] cnt;
    } tx_st_t;

    tx_st_t q, n;

    always_comb begin
        n    = q;
        done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                n.busy = 1'b1;
                n.cnt  = '0;
                n.bits = '0;
                n.sh   = nine ? {1'b1, b8, din, 1'b0} : {1'b1, 1'b1, din, 1'b0};
                n.last = nine ? BW'(FW - 1) : BW'(FW - 2);
            end
        end else if (tick) begin
            if (q.cnt == CW'(OSR - 1)) begin
                n.cnt = '0;
                n.sh  = {1'b1, q.sh[FW-1:1]};
                if (q.bits == q.last) begin
                    n.busy = 1'b0;
                    done   = 1'b1;
                end else begin
                    n.bits = q.bits + 1'b1;
                end
            end else begin
                n.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy = q.busy;
    assign txd  = q.busy ? q.sh[0] : 1'b1;
endmodule

// File: rtl/mpu_rx.sv
module mpu_rx
    import mpu_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        en,
    input  logic        nine,
    input  logic        rxd,
    output logic        valid,
    output logic [DW:0] frame,
    output logic        stop_ok
);
    localparam int CW  = $clog2(OSR);
    localparam int BW  = $clog2(DW + 1);
    localparam int MID = OSR / 2 - 1;

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [BW-1:0] bits;
        logic [DW:0]   sh;
        logic          s1;
        logic          s2;
        logic          s3;
    } rx_st_t;

    rx_st_t q, n;
    logic [BW-1:0] last_bit;

    assign last_bit = nine ? BW'(DW) : BW'(DW - 1);

    always_comb begin
        n     = q;
        n.s1  = rxd;
        n.s2  = q.s1;
        n.s3  = q.s2;
        valid = 1'b0;
        if (!en) begin
            n.st = RX_IDLE;
        end else begin
            case (q.st)
                RX_IDLE: begin
                    if (q.s3 && !q.s2) begin
                        n.st  = RX_START;
                        n.cnt = '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (q.cnt == CW'(MID)) begin
                            n.cnt  = '0;
                            n.bits = '0;
                            n.sh   = '0;
                            n.st   = q.s2 ? RX_IDLE : RX_DATA;
                        end else begin
                            n.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (q.cnt == CW'(OSR - 1)) begin
                            n.cnt  = '0;
                            n.sh   = {q.s2, q.sh[DW:1]};
                            n.bits = q.bits + 1'b1;
                            if (q.bits == last_bit) n.st = RX_STOP;
                        end else begin
                            n.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (q.cnt == CW'(OSR - 1)) begin
                            valid = 1'b1;
                            n.st  = RX_IDLE;
                            n.cnt = '0;
                        end else begin
                            n.cnt = q.cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: RX_IDLE, cnt: '0, bits: '0, sh: '0, s1: 1'b1, s2: 1'b1, s3: 1'b1};
        else        q <= n;
    end

    assign frame   = nine ? q.sh : {q.s2, q.sh[DW:1]};
    assign stop_ok = q.s2;
endmodule

// File: rtl/mpu_match.sv
module mpu_match #(
    parameter int DW = 8
) (
    input  logic [DW:0]   frame,
    input  logic [DW-1:0] station,
    input  logic [DW-1:0] mask,
    output logic          hit
);
    logic bcast;
    logic masked_eq;

    assign bcast     = &frame;
    assign masked_eq = ((frame[DW-1:0] ^ station) & mask) == '0;
    assign hit       = frame[DW] && (bcast || masked_eq);
endmodule

// File: rtl/mpu_uart.sv
module mpu_uart
    import mpu_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16,
    parameter int AW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [AW-1:0] host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          rxd,
    output logic          txd,
    output logic          irq
);
    typedef struct packed {
        logic [DW-1:0] hold;
        logic          unread;
        logic          rx_done;
        logic          tx_done;
        logic          tx_b8;
        logic          rx_b8;
        logic          rx_en;
        logic          nine;
        logic          mp_en;
        logic          ferr;
        logic          ovr;
        logic          matched;
        logic [DW-1:0] station;
        logic [DW-1:0] mask;
    } reg_st_t;

    reg_st_t q, n;

    logic          tx_start, tx_busy, tx_fin;
    logic          rx_valid, rx_stop_ok, addr_hit;
    logic [DW:0]   rx_frame;
    logic          rd_pop, filt, deliver;
    logic          rx_done_flag, tx_done_flag, rx_en_flag, ovr_flag;
    logic [DW-1:0] hold_val;

    assign tx_start = host_wr && (host_addr == AW'(A_DATA));
    assign rd_pop   = host_rd && (host_addr == AW'(A_DATA));

    mpu_tx #(.DW(DW), .OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(tx_start),
        .nine(q.nine), .din(host_wdata), .b8(q.tx_b8),
        .busy(tx_busy), .done(tx_fin), .txd(txd)
    );

    mpu_rx #(.DW(DW), .OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(q.rx_en),
        .nine(q.nine), .rxd(rxd), .valid(rx_valid),
        .frame(rx_frame), .stop_ok(rx_stop_ok)
    );

    mpu_match #(.DW(DW)) u_match (
        .frame(rx_frame), .station(q.station), .mask(q.mask), .hit(addr_hit)
    );

    always_comb begin
        n       = q;
        deliver = 1'b0;
        filt    = q.nine && q.mp_en;
        if (!q.mp_en) n.matched = 1'b0;

        if (host_wr) begin
            if (host_addr == AW'(A_CTRL)) begin
                n.rx_done = q.rx_done & host_wdata[0];
                n.tx_done = q.tx_done & host_wdata[1];
                n.tx_b8   = host_wdata[2];
                n.rx_en   = host_wdata[4];
                n.nine    = host_wdata[5];
                n.mp_en   = host_wdata[6];
            end else if (host_addr == AW'(A_ERR)) begin
                n.ferr = q.ferr & host_wdata[0];
                n.ovr  = q.ovr  & host_wdata[1];
            end else if (host_addr == AW'(A_SADDR)) begin
                n.station = host_wdata;
            end else if (host_addr == AW'(A_MASK)) begin
                n.mask = host_wdata;
            end
        end

        if (rd_pop) n.unread = 1'b0;
        if (tx_fin) n.tx_done = 1'b1;

        if (rx_valid) begin
            if (!filt) begin
                deliver = 1'b1;
            end else if (rx_frame[DW]) begin
                if (addr_hit) begin
                    deliver   = 1'b1;
                    n.matched = 1'b1;
                end
            end else begin
                deliver = q.matched;
            end
        end

        if (deliver) begin
            n.hold    = rx_frame[DW-1:0];
            n.rx_b8   = rx_frame[DW];
            n.rx_done = 1'b1;
            n.unread  = 1'b1;
            if (!rx_stop_ok) n.ferr = 1'b1;
            if (q.unread && !rd_pop) n.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        host_rdata = '0;
        if (host_addr == AW'(A_DATA))
            host_rdata = q.hold;
        else if (host_addr == AW'(A_CTRL))
            host_rdata = DW'({q.mp_en, q.nine, q.rx_en, q.rx_b8, q.tx_b8, q.tx_done, q.rx_done});
        else if (host_addr == AW'(A_ERR))
            host_rdata = DW'({q.ovr, q.ferr});
        else if (host_addr == AW'(A_SADDR))
            host_rdata = q.station;
        else if (host_addr == AW'(A_MASK))
            host_rdata = q.mask;
    end

    assign irq          = q.rx_done | q.tx_done;
    assign rx_done_flag = q.rx_done;
    assign tx_done_flag = q.tx_done;
    assign rx_en_flag   = q.rx_en;
    assign ovr_flag     = q.ovr;
    assign hold_val     = q.hold;
endmodule

// File: rtl/mpu_uart_chk.sv
module mpu_uart_chk
    import mpu_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_wr,
    input logic [AW-1:0] host_addr,
    input logic [DW-1:0] host_wdata,
    input logic          txd,
    input logic          tx_busy,
    input logic          tx_done_flag,
    input logic          rx_done_flag,
    input logic          rx_en_flag,
    input logic          rx_valid,
    input logic          deliver,
    input logic          ovr_flag,
    input logic [DW-1:0] hold_val
);
    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd); // R2

    AST_TXDONE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done_flag) |-> ($past(tx_busy) && !tx_busy)); // R3

    AST_RXDONE_HOST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_done_flag) |-> $past(host_wr && host_addr == AW'(A_CTRL) && !host_wdata[0])); // R5

    AST_TXDONE_HOST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_done_flag) |-> $past(host_wr && host_addr == AW'(A_CTRL) && !host_wdata[1])); // R5

    AST_HOLD_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(deliver) |-> $stable(hold_val)); // R4

    AST_RX_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_flag |-> !rx_valid); // R9

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !(host_wr && host_addr == AW'(A_ERR) && !host_wdata[1])) |=> ovr_flag); // R8
endmodule

bind mpu_uart mpu_uart_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .txd(txd), .tx_busy(tx_busy),
    .tx_done_flag(tx_done_flag), .rx_done_flag(rx_done_flag),
    .rx_en_flag(rx_en_flag), .rx_valid(rx_valid), .deliver(deliver),
    .ovr_flag(ovr_flag), .hold_val(hold_val)
);

// File: tb/tb_mpu_uart.sv
module tb_mpu_uart;
    localparam int BITC = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tc = '0;
    logic       tick;
    logic [2:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       rxd = 1'b1;
    logic       txd;
    logic       irq;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;
    always_ff @(posedge clk) tc <= tc + 2'd1;
    assign tick = &tc;

    mpu_uart dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .host_addr(host_addr),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .rxd(rxd), .txd(txd), .irq(irq)
    );

    // {nine, mp, station, mask, frame[8:0], accept}
    localparam logic [27:0] VEC [10] = '{
        {1'b0, 1'b0, 8'h00, 8'h00, 9'h0A5, 1'b1},
        {1'b1, 1'b0, 8'h00, 8'h00, 9'h13C, 1'b1},
        {1'b1, 1'b0, 8'h00, 8'h00, 9'h0C3, 1'b1},
        {1'b1, 1'b1, 8'h42, 8'hFF, 9'h142, 1'b1},
        {1'b1, 1'b1, 8'h42, 8'hFF, 9'h143, 1'b0},
        {1'b1, 1'b1, 8'h42, 8'hF0, 9'h14F, 1'b1},
        {1'b1, 1'b1, 8'h42, 8'hF0, 9'h152, 1'b0},
        {1'b1, 1'b1, 8'h00, 8'hFF, 9'h1FF, 1'b1},
        {1'b1, 1'b1, 8'h00, 8'hFF, 9'h0FF, 1'b0},
        {1'b1, 1'b1, 8'h99, 8'h00, 9'h155, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic pop(output logic [7:0] d);
        @(negedge clk);
        host_addr = 3'd0; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic send(input logic [8:0] v, input bit nine, input logic stopv);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = v[i];
            repeat (BITC) @(negedge clk);
        end
        if (nine) begin
            rxd = v[8];
            repeat (BITC) @(negedge clk);
        end
        rxd = stopv;
        repeat (BITC) @(negedge clk);
        rxd = 1'b1;
        repeat (BITC) @(negedge clk);
    endtask

    task automatic grab(input bit nine, output logic [8:0] v, output logic stopv);
        v = '0;
        while (txd !== 1'b0) @(negedge clk);
        repeat (BITC / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (BITC) @(negedge clk);
            v[i] = txd;
        end
        if (nine) begin
            repeat (BITC) @(negedge clk);
            v[8] = txd;
        end
        repeat (BITC) @(negedge clk);
        stopv = txd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] d, pre;
        logic [8:0] tv;
        logic       sv;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        hr(3'd0, d); chk("R1 data", d, 8'h00);
        hr(3'd1, d); chk("R1 ctrl", d, 8'h00);
        hr(3'd2, d); chk("R1 err", d, 8'h00);
        hr(3'd3, d); chk("R1 station", d, 8'h00);
        hr(3'd4, d); chk("R1 mask", d, 8'h00);
        chk("R1 txd", txd, 1'b1);
        chk("R1 irq", irq, 1'b0);

        // R12 readback
        hw(3'd3, 8'hA7); hr(3'd3, d); chk("R12 station", d, 8'hA7);
        hw(3'd4, 8'h5E); hr(3'd4, d); chk("R12 mask", d, 8'h5E);
        hw(3'd1, 8'h74); hr(3'd1, d); chk("R12 ctrl", d, 8'h74);

        // R4 R6 R10: receive table
        for (int k = 0; k < 10; k++) begin
            logic       nine, mp, acc;
            logic [8:0] fr;
            nine = VEC[k][27]; mp = VEC[k][26]; fr = VEC[k][9:1]; acc = VEC[k][0];
            hw(3'd1, 8'h00);
            hw(3'd2, 8'h00);
            hw(3'd3, VEC[k][25:18]);
            hw(3'd4, VEC[k][17:10]);
            pop(pre);
            hw(3'd1, {1'b0, mp, nine, 1'b1, 4'b0000});
            send(fr, nine, 1'b1);
            hr(3'd1, d);
            chk($sformatf("R10 R4 vec%0d rx_done", k), d[0], acc);
            hr(3'd0, d);
            chk($sformatf("R10 R4 vec%0d hold", k), d, acc ? fr[7:0] : pre);
            if (acc) begin
                hr(3'd1, d);
                chk($sformatf("R6 vec%0d ninth", k), d[3], nine ? fr[8] : 1'b1);
            end
        end

        // R11 match persists, mismatch does not cancel, disable cancels
        hw(3'd1, 8'h00); hw(3'd3, 8'h42); hw(3'd4, 8'hFF);
        hw(3'd1, 8'h70);
        send(9'h142, 1'b1, 1'b1); pop(d);
        hw(3'd1, 8'h70);
        send(9'h0AB, 1'b1, 1'b1);
        hr(3'd1, d); chk("R11 data after match flag", d[0], 1'b1);
        pop(d); chk("R11 data after match", d, 8'hAB);
        hw(3'd1, 8'h70);
        send(9'h143, 1'b1, 1'b1);
        hr(3'd1, d); chk("R11 other address discarded", d[0], 1'b0);
        send(9'h0CD, 1'b1, 1'b1);
        pop(d); chk("R11 match kept", d, 8'hCD);
        hw(3'd1, 8'h30); hw(3'd1, 8'h70);
        send(9'h077, 1'b1, 1'b1);
        hr(3'd1, d); chk("R11 match cancelled flag", d[0], 1'b0);
        hr(3'd0, d); chk("R11 match cancelled hold", d, 8'hCD);

        // R8 overrun
        hw(3'd1, 8'h10); hw(3'd2, 8'h00);
        send(9'h011, 1'b0, 1'b1);
        send(9'h022, 1'b0, 1'b1);
        hr(3'd2, d); chk("R8 overrun set", d[1], 1'b1);
        hr(3'd0, d); chk("R8 newest kept", d, 8'h22);
        hw(3'd2, 8'h02); hr(3'd2, d); chk("R8 R5 write 1 keeps", d[1], 1'b1);
        hw(3'd2, 8'h00); hr(3'd2, d); chk("R8 R5 write 0 clears", d[1], 1'b0);
        pop(d);
        send(9'h033, 1'b0, 1'b1);
        hr(3'd2, d); chk("R8 no overrun after read", d[1], 1'b0);
        pop(d); chk("R8 byte", d, 8'h33);

        // R7 frame error
        hw(3'd1, 8'h10);
        send(9'h05A, 1'b0, 1'b0);
        hr(3'd2, d); chk("R7 frame error", d[0], 1'b1);
        hr(3'd1, d); chk("R7 still delivered", d[0], 1'b1);
        chk("R6 stop as ninth", d[3], 1'b0);
        pop(d); chk("R7 byte", d, 8'h5A);

        // R9 receive disabled
        hw(3'd1, 8'h00);
        send(9'h066, 1'b0, 1'b1);
        hr(3'd1, d); chk("R9 no done", d[0], 1'b0);
        hr(3'd0, d); chk("R9 hold unchanged", d, 8'h5A);

        // R4 false start glitch
        hw(3'd1, 8'h10);
        @(negedge clk); rxd = 1'b0;
        repeat (16) @(negedge clk); rxd = 1'b1;
        repeat (12 * BITC) @(negedge clk);
        hr(3'd1, d); chk("R4 glitch dropped", d[0], 1'b0);
        hr(3'd0, d); chk("R4 glitch hold", d, 8'h5A);

        // R2 R3 R5 transmit, 8-bit, busy write ignored
        hw(3'd1, 8'h00);
        chk("R5 irq low", irq, 1'b0);
        hw(3'd0, 8'hC5);
        hw(3'd0, 8'h00);
        grab(1'b0, tv, sv);
        chk("R2 tx byte", tv[7:0], 8'hC5);
        chk("R2 tx stop", sv, 1'b1);
        repeat (BITC) @(negedge clk);
        hr(3'd1, d); chk("R3 tx done", d[1], 1'b1);
        chk("R5 irq high", irq, 1'b1);
        hw(3'd1, 8'h02); hr(3'd1, d); chk("R5 write 1 keeps", d[1], 1'b1);
        hw(3'd1, 8'h00); hr(3'd1, d); chk("R5 write 0 clears", d[1], 1'b0);
        chk("R5 irq cleared", irq, 1'b0);

        // R2 transmit, 9-bit
        hw(3'd1, 8'h24);
        hw(3'd0, 8'h3C);
        grab(1'b1, tv, sv);
        chk("R2 tx9 byte", tv[7:0], 8'h3C);
        chk("R2 tx9 ninth", tv[8], 1'b1);
        chk("R2 tx9 stop", sv, 1'b1);
        repeat (BITC) @(negedge clk);
        hr(3'd1, d); chk("R3 tx9 done", d[1], 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule